// File: doc/BRIEF.md
# Cell Byte Unpacker with Pad Removal

This block reads cells out of a buffer that holds them as 16-bit words and sends them to a receiver one byte per clock. The low byte of each word goes out first, then the high byte. A cell with an odd byte count is stored with one filler byte in the upper half of its final word. The unpacker never sends that filler byte, so the receiver sees exactly the programmed number of bytes.

The output side acts as the master of a Utopia-style handshake. When the buffer reports a complete cell and the receiver asserts cell-available, the unpacker starts the cell on the next clock. It raises its enable and marks the first byte with start-of-cell. It then streams every byte of the cell with no gaps. The buffer's read pointer steps forward one word after each byte pair, and also after the final byte of the cell.

Top module: `cell_unpacker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `tx_en`, `tx_soc` and `rd_adv` are low.
- R2: A cell starts only after a rising edge in the idle state at which both `rx_clav` and `cell_rdy` are high. `tx_en` goes high in the following cycle. If only one of the two is high, `tx_en` stays low.
- R3: `tx_soc` is high in the first enabled cycle of each cell and low in all other cycles.
- R4: Byte k of a cell is taken from word k/2. Even k takes bits [7:0] and odd k takes bits [15:8].
- R5: A cell carries exactly `cell_len` bytes. For odd `cell_len`, the pad byte in bits [15:8] of the last word is never output.
- R6: `rd_adv` is high during byte k exactly when k is odd or k is the last byte, giving ceil(`cell_len`/2) advances per cell.
- R7: Once started, `tx_en` stays high for `cell_len` consecutive cycles, even if `rx_clav` falls.
- R8: `cell_len` is captured when a cell starts. Changing it during the cell has no effect on that cell.
- R9: After the last byte, `tx_en` is low for at least one cycle. It stays low while `rx_clav` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_len | input | LEN_W | Cell length in bytes (1 or more) |
| cell_rdy | input | 1 | Buffer holds at least one complete cell |
| rd_word | input | 2*BYTE_W | Word at the buffer's current read pointer |
| rd_adv | output | 1 | Step the buffer read pointer by one word |
| rx_clav | input | 1 | Receiver can accept a cell |
| tx_en | output | 1 | Output byte valid, transfers on this edge |
| tx_soc | output | 1 | First byte of a cell |
| tx_byte | output | BYTE_W | Output byte |

## Verification
The bench sweeps cell lengths from 1 to 20 and adds 63, 64 and 127, so both odd and even lengths are covered at both extremes.
- **Pad byte and count:** Any mistake in handling the pad would show up as an extra filler byte, a lost final byte, or a read pointer left one word short. Each of these breaks the byte-value check, the byte-count check or the pointer count.
- **Handshake timing:** The bench drops `rx_clav` and alters `cell_len` right after the first byte. A design that re-samples either signal mid-cell would stall early or truncate the cell.
- **Start conditions:** The bench holds each start condition alone for several cycles. A design that starts on only one of `rx_clav` or `cell_rdy` would be caught there.

// File: rtl/cell_unpacker.sv
module cell_unpacker #(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LEN_W-1:0]      cell_len,
  input  logic                  cell_rdy,
  input  logic [2*BYTE_W-1:0]   rd_word,
  output logic                  rd_adv,
  input  logic                  rx_clav,
  output logic                  tx_en,
  output logic                  tx_soc,
  output logic [BYTE_W-1:0]     tx_byte
);
  localparam logic [LEN_W-1:0] ONE = 1;

  logic             busy;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] len_q;
  logic             last;

  assign last = idx == len_q - ONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      len_q <= '0;
    end else if (!busy) begin
      if (rx_clav && cell_rdy) begin
        busy  <= 1'b1;
        idx   <= '0;
        len_q <= cell_len;
      end
    end else begin
      if (last) busy <= 1'b0;
      idx <= idx + ONE;
    end
  end

  assign tx_en   = busy;
  assign tx_soc  = busy && (idx == '0);
  assign tx_byte = idx[0] ? rd_word[2*BYTE_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
  assign rd_adv  = busy && (idx[0] || last);
endmodule

module cell_unpacker_chk (
  input logic clk,
  input logic rst_n,
  input logic cell_rdy,
  input logic rx_clav,
  input logic rd_adv,
  input logic tx_en,
  input logic tx_soc
);
  p_start_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(rx_clav && cell_rdy));

  p_soc_on_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> tx_soc);

  p_soc_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |=> !tx_soc);

  p_soc_only_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soc |-> tx_en);

  p_adv_only_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv |-> tx_en);

  p_end_advances_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> $past(rd_adv));

  p_no_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !rd_adv) |=> tx_en);
endmodule

bind cell_unpacker cell_unpacker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cell_rdy(cell_rdy), .rx_clav(rx_clav),
  .rd_adv(rd_adv), .tx_en(tx_en), .tx_soc(tx_soc)
);

// File: tb/cell_unpacker_tb.sv
module cell_unpacker_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  cell_len = 7'd1;
  logic        cell_rdy = 0;
  logic        rx_clav = 0;
  logic [15:0] rd_word;
  logic        rd_adv, tx_en, tx_soc;
  logic [7:0]  tx_byte;

  logic [15:0] mem [0:63];
  int ptr = 0;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  assign rd_word = mem[ptr % 64];
  always @(posedge clk) if (rd_adv) ptr <= ptr + 1;

  cell_unpacker dut_i (
    .clk(clk), .rst_n(rst_n), .cell_len(cell_len), .cell_rdy(cell_rdy),
    .rd_word(rd_word), .rd_adv(rd_adv), .rx_clav(rx_clav),
    .tx_en(tx_en), .tx_soc(tx_soc), .tx_byte(tx_byte)
  );

  function automatic logic [7:0] bval(int len, int k);
    return 8'((len * 13 + k * 7 + 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cell(input int len);
    int words = (len + 1) / 2;
    int base = ptr;
    int cnt = 0;
    for (int w = 0; w < words; w++) begin
      logic [7:0] hi;
      hi = (2 * w + 1 < len) ? bval(len, 2 * w + 1) : 8'h5A;
      mem[(base + w) % 64] = {hi, bval(len, 2 * w)};
    end
    cell_len = 7'(len);
    cell_rdy = 1; rx_clav = 0;
    repeat (3) @(negedge clk);
    chk(tx_en == 0, "R2 rdy-only", tx_en, 0);
    cell_rdy = 0; rx_clav = 1;
    repeat (3) @(negedge clk);
    chk(tx_en == 0, "R2 clav-only", tx_en, 0);
    cell_rdy = 1;
    @(negedge clk);
    chk(tx_en == 1, "R2 start", tx_en, 1);
    while (tx_en && cnt < 200) begin
      chk(tx_soc == (cnt == 0), "R3 soc", tx_soc, cnt == 0);
      chk(tx_byte == bval(len, cnt), "R4/R5 byte", tx_byte, bval(len, cnt));
      chk(rd_adv == ((cnt % 2 == 1) || (cnt == len - 1)), "R6 adv", rd_adv,
          (cnt % 2 == 1) || (cnt == len - 1));
      if (cnt == 0) begin
        rx_clav = 0;            // R7: clav drop must not stall
        cell_len = 7'(len) ^ 7'h55;  // R8: mid-cell change ignored
      end
      cnt++;
      @(negedge clk);
    end
    chk(cnt == len, "R5/R7/R8 byte count", cnt, len);
    chk(ptr - base == words, "R6 words advanced", ptr - base, words);
    cell_len = 7'(len);
    repeat (2) @(negedge clk);
    chk(tx_en == 0, "R9 idle after cell", tx_en, 0);
    cell_rdy = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(tx_en == 0 && tx_soc == 0 && rd_adv == 0, "R1 in reset",
        {tx_en, tx_soc, rd_adv}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(tx_en == 0 && tx_soc == 0 && rd_adv == 0, "R1 after reset",
        {tx_en, tx_soc, rd_adv}, 0);
    for (int l = 1; l <= 20; l++) do_cell(l);
    do_cell(63);
    do_cell(64);
    do_cell(127);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule